// File: doc/BRIEF.md
# Two-Lane Bitslip Word-Alignment Trainer

This block takes two serial data lanes. Each lane is sampled once per cycle of a single bit-rate clock. Every six cycles the block turns each lane into a 6-bit word, so a lane rate of 600 Mb/s gives one 12-bit parallel word per 100 MHz word time. A lane can reach the receiver skewed by a whole number of bit times. Its word boundary may then fall anywhere inside the six-bit frame. To correct this, each lane has its own realignment stage. The stage rotates the captured word right by one bit each time it receives a slip pulse.

Each lane has its own training state machine. When `train_start` is pulsed, the machine compares the lane's aligned word against that lane's half of a fixed training pattern. The pattern is a parameter with default 12'hBCD. The machine keeps slipping the lane until the word matches, then locks the lane. If a full rotation fails to produce a match, the machine gives up and flags the lane as failed. The parallel output stays at zero with `data_valid` low until every lane is locked. After that, aligned data passes through once per word.

The states of the lane machine are IDLE, SETTLE, COMPARE, SLIP, LOCKED and FAILED. Its transitions are:
- **start**: any state goes to SETTLE when `train_start` is high, and the slip count is cleared.
- **settled**: SETTLE goes to COMPARE after two compare strobes.
- **matched**: COMPARE goes to LOCKED after four consecutive matching words.
- **mismatch**: COMPARE goes to SLIP when a word mismatches and fewer than six slips have been made.
- **exhausted**: COMPARE goes to FAILED when a word mismatches after six slips.
- **slipped**: SLIP goes to SETTLE after its single cycle, which is the slip pulse.

LOCKED and FAILED hold until the next start.

Top module: `bitslip_aligner`

## Requirements
- R1: Each lane is deserialized into 6-bit words. The first bit of a word to arrive lands in bit 5 and the last in bit 0. Once all lanes are locked, `data_valid` pulses for one cycle exactly once every 6 clock cycles.
- R2: Lane 1 drives `data_out[11:6]` and lane 0 drives `data_out[5:0]`. Lane 1 is compared against PATTERN[11:6] (default 6'b101111) and lane 0 against PATTERN[5:0] (default 6'b001101).
- R3: Each slip pulse rotates that lane's word right by one bit, for example 6'b111110 becomes 6'b011111. Lanes slip independently, so each lane locks whatever its skew in the range 0 to 5 bits.
- R4: After every slip, a lane ignores two compare strobes before comparing again. With a 1-bit skew on both lanes, lock cannot come before 48 cycles after the start edge and is present by 56 cycles.
- R5: A lane locks only after 4 consecutive matching words. With no skew, `lane_locked` is still low 30 cycles after the start edge and high 40 cycles after it.
- R6: A lane that still mismatches after 6 slips raises its `lane_fail` bit and `train_fail`. It stops slipping and stays failed. The other lane trains and locks unaffected.
- R7: `train_start` clears all lock and fail flags on the next cycle, resets each lane's slip count and rotation to zero, and restarts training.
- R8: `data_out` is zero and `data_valid` is low whenever not all lanes are locked. Once all lanes are locked, `data_out` carries the aligned words.
- R9: After reset all outputs are zero. Lanes stay untrained until `train_start` is pulsed.
- R10: A locked lane stays locked, and keeps its rotation, until the next `train_start`, whatever data follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_start | input | 1 | One-cycle pulse that restarts training on all lanes |
| serial_in | input | 2 | Serial bit of each lane, one per clock |
| data_out | output | 12 | Aligned parallel word, lane 1 in the upper half |
| data_valid | output | 1 | One-cycle pulse per new word once all lanes are locked |
| lane_locked | output | 2 | Per-lane lock flag |
| lane_fail | output | 2 | Per-lane training failure flag |
| all_locked | output | 1 | Every lane locked |
| train_fail | output | 1 | Any lane failed |

## Verification
The training pattern is sent with several pairs of lane skews:
- Equal zero skew isolates the four-word lock run.
- Equal one-bit skew exposes the settle wait and the rotation direction, through the exact lock window.
- Unequal skews (2 and 5) show that each lane slips independently.

A lane carrying a constant word that never matches separates the fail path from the healthy lane. A following restart with one-bit skew shows that slip counts and rotations really return to zero. After lock, new data words on both lanes confirm that the rotation is kept and that data passes through at one valid pulse per six cycles.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_COMPARE,
        ST_SLIP,
        ST_LOCKED,
        ST_FAILED
    } train_state_t;

endpackage

// File: rtl/bitslip_word_timer.sv
module bitslip_word_timer #(
    parameter int W = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic capture,
    output logic word_stb,
    output logic cmp_stb
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] phase_q;

    assign capture = (phase_q == CW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= '0;
            word_stb <= 1'b0;
            cmp_stb  <= 1'b0;
        end else begin
            phase_q  <= capture ? '0 : phase_q + 1'b1;
            word_stb <= capture;
            cmp_stb  <= word_stb;
        end
    end
endmodule

// File: rtl/bitslip_lane_deser.sv
module bitslip_lane_deser #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         serial_in,
    input  logic         capture,
    input  logic         word_stb,
    input  logic         slip,
    output logic [W-1:0] aligned
);
    localparam int RW = $clog2(W);

    logic [W-2:0]   shift_q;
    logic [W-1:0]   raw_q;
    logic [RW-1:0]  rot_q;
    logic [2*W-1:0] doubled;
    logic [W-1:0]   rotated;

    // rotate right by rot_q: take the low W bits of the doubled word shifted down
    assign doubled = {raw_q, raw_q};
    assign rotated = W'(doubled >> rot_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            raw_q   <= '0;
            rot_q   <= '0;
            aligned <= '0;
        end else begin
            shift_q <= {shift_q[W-3:0], serial_in};
            if (capture)
                raw_q <= {shift_q, serial_in};
            if (clear)
                rot_q <= '0;
            else if (slip)
                rot_q <= (rot_q == RW'(W - 1)) ? '0 : rot_q + 1'b1;
            if (word_stb)
                aligned <= rotated;
        end
    end
endmodule

// File: rtl/bitslip_lane_trainer.sv
module bitslip_lane_trainer
    import bitslip_pkg::*;
#(
    parameter int           W            = 6,
    parameter logic [W-1:0] EXPECT       = '0,
    parameter int           SETTLE_WORDS = 2,
    parameter int           LOCK_RUN     = 4,
    parameter int           MAX_SLIPS    = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_stb,
    input  logic [W-1:0] word_in,
    output logic         slip,
    output logic         locked,
    output logic         failed
);
    localparam int SW = $clog2(SETTLE_WORDS + 1);
    localparam int MW = $clog2(LOCK_RUN + 1);
    localparam int PW = $clog2(MAX_SLIPS + 1);

    train_state_t  state_q, state_d;
    logic [SW-1:0] settle_q;
    logic [MW-1:0] match_q;
    logic [PW-1:0] slips_q;
    logic          hit;

    assign hit = (word_in == EXPECT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_SETTLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_SETTLE:  if (cmp_stb && settle_q == SW'(SETTLE_WORDS - 1))
                                state_d = ST_COMPARE;
                ST_COMPARE: if (cmp_stb) begin
                                if (hit) begin
                                    if (match_q == MW'(LOCK_RUN - 1)) state_d = ST_LOCKED;
                                end else if (slips_q == PW'(MAX_SLIPS)) begin
                                    state_d = ST_FAILED;
                                end else begin
                                    state_d = ST_SLIP;
                                end
                            end
                ST_SLIP:    state_d = ST_SETTLE;
                ST_LOCKED:  state_d = ST_LOCKED;
                ST_FAILED:  state_d = ST_FAILED;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= '0;
            match_q  <= '0;
            slips_q  <= '0;
        end else begin
            if (start || state_q != ST_SETTLE) settle_q <= '0;
            else if (cmp_stb)                  settle_q <= settle_q + 1'b1;

            if (start || state_q != ST_COMPARE) match_q <= '0;
            else if (cmp_stb && hit)            match_q <= match_q + 1'b1;

            if (start)                   slips_q <= '0;
            else if (state_q == ST_SLIP) slips_q <= slips_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        slip   = (state_q == ST_SLIP);
        locked = (state_q == ST_LOCKED);
        failed = (state_q == ST_FAILED);
    end
endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
    parameter int                          FACTOR       = 6,
    parameter int                          LANES        = 2,
    parameter logic [FACTOR*LANES-1:0]     PATTERN      = 12'hBCD,
    parameter int                          SETTLE_WORDS = 2,
    parameter int                          LOCK_RUN     = 4,
    parameter int                          MAX_SLIPS    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    train_start,
    input  logic [LANES-1:0]        serial_in,
    output logic [FACTOR*LANES-1:0] data_out,
    output logic                    data_valid,
    output logic [LANES-1:0]        lane_locked,
    output logic [LANES-1:0]        lane_fail,
    output logic                    all_locked,
    output logic                    train_fail
);
    localparam int DW = FACTOR * LANES;

    logic          capture, word_stb, cmp_stb;
    logic [LANES-1:0] slip_pulse;
    logic [DW-1:0] aligned_all;

    bitslip_word_timer #(.W(FACTOR)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .word_stb (word_stb),
        .cmp_stb  (cmp_stb)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bitslip_lane_deser #(.W(FACTOR)) u_deser (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (train_start),
            .serial_in (serial_in[g]),
            .capture   (capture),
            .word_stb  (word_stb),
            .slip      (slip_pulse[g]),
            .aligned   (aligned_all[g*FACTOR +: FACTOR])
        );

        bitslip_lane_trainer #(
            .W            (FACTOR),
            .EXPECT       (PATTERN[g*FACTOR +: FACTOR]),
            .SETTLE_WORDS (SETTLE_WORDS),
            .LOCK_RUN     (LOCK_RUN),
            .MAX_SLIPS    (MAX_SLIPS)
        ) u_trainer (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (train_start),
            .cmp_stb (cmp_stb),
            .word_in (aligned_all[g*FACTOR +: FACTOR]),
            .slip    (slip_pulse[g]),
            .locked  (lane_locked[g]),
            .failed  (lane_fail[g])
        );
    end

    assign all_locked = &lane_locked;
    assign train_fail = |lane_fail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out   <= '0;
            data_valid <= 1'b0;
        end else if (!all_locked) begin
            data_out   <= '0;
            data_valid <= 1'b0;
        end else begin
            data_valid <= cmp_stb;
            if (cmp_stb) data_out <= aligned_all;
        end
    end
endmodule

// File: rtl/bitslip_aligner_chk.sv
module bitslip_aligner_chk #(
    parameter int LANES = 2,
    parameter int DW    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             train_start,
    input logic [LANES-1:0] slip_pulse,
    input logic [DW-1:0]    data_out,
    input logic             data_valid,
    input logic [LANES-1:0] lane_locked,
    input logic [LANES-1:0] lane_fail,
    input logic             all_locked
);
    // R1
    valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |=> (lane_locked == '0 && lane_fail == '0));

    // R8
    output_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !all_locked |=> (data_out == '0 && !data_valid));

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        // R3
        slip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slip_pulse[g] |=> !slip_pulse[g]);

        // R10
        lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_locked[g] && !train_start) |=> lane_locked[g]);

        // R6
        fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_fail[g] && !train_start) |=> (lane_fail[g] && !lane_locked[g]));

        // R6
        fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lane_fail[g] |-> !slip_pulse[g]);
    end
endmodule

bind bitslip_aligner bitslip_aligner_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .train_start (train_start),
    .slip_pulse  (slip_pulse),
    .data_out    (data_out),
    .data_valid  (data_valid),
    .lane_locked (lane_locked),
    .lane_fail   (lane_fail),
    .all_locked  (all_locked)
);

// File: tb/bitslip_aligner_tb.sv
module bitslip_aligner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        train_start = 1'b0;
    logic [1:0]  serial_in;
    logic [11:0] data_out;
    logic        data_valid;
    logic [1:0]  lane_locked, lane_fail;
    logic        all_locked, train_fail;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int cyc = 0;
    logic [5:0] tx_word [2];
    int         skew [2];

    always #2 clk = ~clk;

    bitslip_aligner u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .train_start (train_start),
        .serial_in   (serial_in),
        .data_out    (data_out),
        .data_valid  (data_valid),
        .lane_locked (lane_locked),
        .lane_fail   (lane_fail),
        .all_locked  (all_locked),
        .train_fail  (train_fail)
    );

    // serial source: bit n of lane i; first bit of each word is bit 5
    function automatic logic tx_bit(logic [5:0] w, int d, int idx);
        logic [2:0] pos;
        pos = 3'(5 - ((idx + d) % 6));
        return w[pos];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    always_comb begin
        serial_in[1] = tx_bit(tx_word[1], skew[1], n);
        serial_in[0] = tx_bit(tx_word[0], skew[0], n);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    // leaves the bench at the falling edge half a cycle after the start edge
    task automatic pulse_start();
        @(negedge clk) train_start = 1'b1;
        @(negedge clk) train_start = 1'b0;
    endtask

    task automatic wait_settled();
        for (int i = 0; i < 400; i++) begin
            if (all_locked || train_fail) break;
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic set_lanes(input logic [5:0] w1, input int d1,
                             input logic [5:0] w0, input int d0);
        tx_word[1] = w1; skew[1] = d1;
        tx_word[0] = w0; skew[0] = d0;
    endtask

    task automatic t_reset();
        check(data_out == 12'h0 && !data_valid, "R9", "outputs in reset", {data_out, data_valid}, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (60) @(negedge clk);
        check(lane_locked == 2'b00 && lane_fail == 2'b00 && !all_locked && !train_fail,
              "R9", "no training before start", {lane_locked, lane_fail}, 0);
        check(data_out == 12'h0 && !data_valid, "R9", "outputs idle", data_out, 0);
    endtask

    task automatic t_lock_run();
        set_lanes(6'b101111, 0, 6'b001101, 0);
        pulse_start();
        repeat (30) @(negedge clk);
        check(lane_locked == 2'b00, "R5", "no lock before four matches", lane_locked, 0);
        repeat (10) @(negedge clk);
        check(lane_locked == 2'b11 && all_locked, "R5", "lock after four matches", lane_locked, 3);
    endtask

    task automatic t_settle();
        set_lanes(6'b101111, 1, 6'b001101, 1);
        pulse_start();
        repeat (48) @(negedge clk);
        check(lane_locked == 2'b00, "R4", "settle delays lock", lane_locked, 0);
        repeat (8) @(negedge clk);
        check(lane_locked == 2'b11, "R3", "one right rotation locks 1-bit skew", lane_locked, 3);
    endtask

    task automatic t_mixed_skew();
        set_lanes(6'b101111, 2, 6'b001101, 5);
        pulse_start();
        wait_settled();
        check(lane_locked == 2'b11 && !train_fail, "R3", "independent slips lock", {lane_locked, lane_fail}, 12);
        check(data_out == 12'hBCD, "R2", "pattern on output halves", data_out, 12'hBCD);
        begin
            int pulses = 0;
            repeat (60) begin
                @(negedge clk);
                if (data_valid) pulses++;
            end
            check(pulses == 10, "R1", "valid once per six cycles", pulses, 10);
        end
    endtask

    task automatic t_functional();
        tx_word[1] = 6'h2A;
        tx_word[0] = 6'h13;
        repeat (30) @(negedge clk);
        check(lane_locked == 2'b11, "R10", "lock held on new data", lane_locked, 3);
        check(data_out == {6'h2A, 6'h13}, "R8", "aligned data passed", data_out, {6'h2A, 6'h13});
        tx_word[1] = 6'h05;
        tx_word[0] = 6'h38;
        repeat (30) @(negedge clk);
        check(data_out == {6'h05, 6'h38}, "R1", "bit order of second word", data_out, {6'h05, 6'h38});
    endtask

    task automatic t_fail();
        set_lanes(6'b000000, 0, 6'b001101, 3);
        pulse_start();
        @(negedge clk);
        check(lane_locked == 2'b00 && lane_fail == 2'b00, "R7", "start clears flags", {lane_locked, lane_fail}, 0);
        repeat (400) @(negedge clk);
        check(lane_fail == 2'b10 && train_fail, "R6", "bad lane fails", lane_fail, 2);
        check(lane_locked == 2'b01 && !all_locked, "R6", "good lane still locks", lane_locked, 1);
        begin
            int pulses = 0;
            repeat (60) begin
                @(negedge clk);
                if (data_valid || data_out != 12'h0) pulses++;
            end
            check(pulses == 0, "R8", "output gated while a lane failed", pulses, 0);
        end
    endtask

    task automatic t_restart();
        set_lanes(6'b101111, 1, 6'b001101, 1);
        pulse_start();
        check(lane_fail == 2'b00 && !train_fail, "R7", "restart clears fail", lane_fail, 0);
        repeat (55) @(negedge clk);
        check(lane_locked == 2'b11, "R7", "slip count and rotation reset", lane_locked, 3);
        repeat (12) @(negedge clk);
        check(data_out == 12'hBCD, "R8", "data after retrain", data_out, 12'hBCD);
    endtask

    initial begin
        set_lanes(6'b101111, 0, 6'b001101, 0);
        repeat (3) @(negedge clk);
        t_reset();
        t_lock_run();
        t_settle();
        t_mixed_skew();
        t_functional();
        t_fail();
        t_restart();
        finish_run();
    end
endmodule